// File: doc/BRIEF.md
# I2C Register Target with Transaction Watchdog

This block is an I2C target that lets a host read and write a small internal register file through 16-bit register addresses. SCL and SDA are sampled on a fast system clock through two-flop synchronisers. SDA is driven open-drain: the block only reports when it pulls the line low. The bus line itself is the wired-AND of the host and the target.

A write transfer sends a 16-bit register pointer, high byte first, and then any number of data bytes. Each data byte is stored at the pointer, and the pointer then increments. A read transfer returns bytes from the current pointer, which also increments after each byte. The register file is indexed by the low bits of the pointer.

A fixed watchdog starts counting system clock cycles at the first START of a transaction. Bus activity does not affect it. When it expires, the target releases SDA at once and ignores the bus until the next START. If SCL is high at that moment, the host sees SDA rise with SCL high, which is a false STOP. Any bytes the host reads after that come back as all ones. A single-cycle flag marks the expiry.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, sda_oe_o and timeout_o are 0 and every register holds 0.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The first byte after START carries a 7-bit address, MSB first, followed by an R/W bit (1 = read). On a match with DEV_ADDR, the target pulls SDA low in the ninth clock. On a mismatch it never drives SDA.
- R3: In a write, the first two data bytes load the pointer, high byte first. Each following byte is stored at the pointer, and the pointer then increments. Every byte is ACKed.
- R4: In a read, the target returns the register at the pointer, MSB first, and increments the pointer after each byte. A host NACK ends the read with SDA released.
- R5: Only the low REG_AW bits of the 16-bit pointer select a register. Pointers that differ only in the upper bits reach the same register.
- R6: timeout_o pulses for exactly one cycle, 2^TIMEOUT_W + 3 cycles after the system clock edge on which the host's START edge is applied. The extra 3 cycles are the synchroniser and detection latency. SCL activity or gaps between bytes do not change this timing.
- R7: A repeated START inside a running window does not restart the watchdog.
- R8: A STOP closes the window, and the next START opens a fresh one. Consecutive short transactions never time out, however long they last in total.
- R9: When the watchdog expires, SDA is released in the same cycle that timeout_o rises, even when SCL is high. Until the next START, the target drives nothing, so read bytes return 0xFF.
- R10: A START after a timeout begins a new transaction that works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw SCL level from the bus |
| sda_i | input | 1 | Raw SDA level from the bus |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| timeout_o | output | 1 | One-cycle pulse on watchdog expiry |

## Verification
- **Pointer errors** appear as wrong read data on the very next byte that uses the pointer. The aliasing read and the back-to-back reads expose an increment or index slip within one byte time.
- **Bit-counter or state errors** move the ACK slot or the data bits by one SCL period. The host sees these on the first byte.
- **Watchdog count errors** shift the timeout_o cycle, which the bench measures to the exact system clock cycle.
- **Release errors on expiry** appear at once as SDA still low while SCL is high, or as a read byte after expiry that is not 0xFF.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WR, ST_ACK, ST_RD, ST_RACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    PH_PTR_HI, PH_PTR_LO, PH_DATA
  } wr_phase_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic [SYNC_N-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_N-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_N-2:0], sda_i};
      scl_d  <= scl_ff[SYNC_N-1];
      sda_d  <= sda_ff[SYNC_N-1];
    end
  end

  assign scl_o      = scl_ff[SYNC_N-1];
  assign sda_o      = sda_ff[SYNC_N-1];
  assign start_o    = scl_o && scl_d && sda_d && !sda_o;
  assign stop_o     = scl_o && scl_d && !sda_d && sda_o;
  assign scl_rise_o = scl_o && !scl_d;
  assign scl_fall_o = !scl_o && scl_d;
endmodule

// File: rtl/i2c_txn_watchdog.sv
module i2c_txn_watchdog #(
  parameter int TW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  output logic          expire_o,
  output logic          timeout_o,
  output logic          armed_o,
  output logic          expired_o,
  output logic [TW-1:0] cnt_o
);
  logic          armed_q, expired_q, to_q;
  logic [TW-1:0] cnt_q;

  assign expire_o = armed_q && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      expired_q <= 1'b0;
      to_q      <= 1'b0;
      cnt_q     <= '0;
    end else begin
      to_q <= 1'b0;
      if (armed_q) begin
        // repeated START ignored while armed
        if (expire_o) begin
          armed_q   <= 1'b0;
          expired_q <= 1'b1;
          to_q      <= 1'b1;
          cnt_q     <= '0;
        end else if (stop_i) begin
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (start_i) begin
        armed_q   <= 1'b1;
        expired_q <= 1'b0;
        cnt_q     <= '0;
      end
    end
  end

  assign timeout_o = to_q;
  assign armed_o   = armed_q;
  assign expired_o = expired_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h36,
  parameter int         AW       = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          abort_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic [7:0]    wdata_o,
  output logic          sda_oe_o
);
  tgt_state_e state_q;
  wr_phase_e  phase_q;
  logic [3:0]  bit_cnt_q;
  logic [7:0]  shreg_q, txreg_q;
  logic [15:0] ptr_q;
  logic        rd_mode_q, oe_q;
  logic        byte_end, bus_evt;

  assign byte_end = scl_fall_i && (bit_cnt_q == 4'd8);
  assign bus_evt  = abort_i || start_i || stop_i;
  assign we_o     = !bus_evt && (state_q == ST_WR) && byte_end && (phase_q == PH_DATA);
  assign addr_o   = ptr_q[AW-1:0];
  assign wdata_o  = shreg_q;
  assign sda_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_PTR_HI;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      txreg_q   <= '0;
      ptr_q     <= '0;
      rd_mode_q <= 1'b0;
      oe_q      <= 1'b0;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise_i && bit_cnt_q < 4'd8) begin
            shreg_q   <= {shreg_q[6:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_end) begin
            bit_cnt_q <= '0;
            if (state_q == ST_ADDR) begin
              if (shreg_q[7:1] == DEV_ADDR) begin
                oe_q      <= 1'b1;
                state_q   <= ST_ACK;
                rd_mode_q <= shreg_q[0];
                phase_q   <= PH_PTR_HI;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              oe_q    <= 1'b1;
              state_q <= ST_ACK;
              unique case (phase_q)
                PH_PTR_HI: begin
                  ptr_q[15:8] <= shreg_q;
                  phase_q     <= PH_PTR_LO;
                end
                PH_PTR_LO: begin
                  ptr_q[7:0] <= shreg_q;
                  phase_q    <= PH_DATA;
                end
                default: ptr_q <= ptr_q + 16'd1;
              endcase
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            bit_cnt_q <= '0;
            if (rd_mode_q) begin
              txreg_q <= rd_data_i;
              oe_q    <= ~rd_data_i[7];
              ptr_q   <= ptr_q + 16'd1;
              state_q <= ST_RD;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WR;
            end
          end
        end
        ST_RD: begin
          if (scl_rise_i) begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall_i) begin
            if (bit_cnt_q == 4'd8) begin
              oe_q      <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= ST_RACK;
            end else begin
              oe_q <= ~txreg_q[3'd7 - bit_cnt_q[2:0]];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) state_q <= sda_i ? ST_IDLE : ST_ACK;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0] DEV_ADDR  = 7'h36,
  parameter int         TIMEOUT_W = 18,
  parameter int         REG_AW    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  output logic timeout_o
);
  logic scl_s, sda_s, start_p, stop_p, scl_rise, scl_fall;
  logic wd_expire, wd_armed, wd_expired;
  logic [TIMEOUT_W-1:0] wd_cnt;
  logic [REG_AW-1:0]    reg_addr;
  logic                 reg_we;
  logic [7:0]           reg_wdata, reg_rdata;

  i2c_bus_sync #(.SYNC_N(2)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .start_o    (start_p),
    .stop_o     (stop_p),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  i2c_txn_watchdog #(.TW(TIMEOUT_W)) u_wd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_p),
    .stop_i    (stop_p),
    .expire_o  (wd_expire),
    .timeout_o (timeout_o),
    .armed_o   (wd_armed),
    .expired_o (wd_expired),
    .cnt_o     (wd_cnt)
  );

  i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .AW(REG_AW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_s),
    .start_i    (start_p),
    .stop_i     (stop_p),
    .abort_i    (wd_expire),
    .rd_data_i  (reg_rdata),
    .addr_o     (reg_addr),
    .we_o       (reg_we),
    .wdata_o    (reg_wdata),
    .sda_oe_o   (sda_oe_o)
  );

  i2c_reg_bank #(.AW(REG_AW), .DW(8)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we),
    .waddr_i (reg_addr),
    .wdata_i (reg_wdata),
    .raddr_i (reg_addr),
    .rdata_o (reg_rdata)
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int TW = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sda_oe_o,
  input logic          timeout_o,
  input logic          scl_s,
  input logic          start_p,
  input logic          wd_armed,
  input logic          wd_expired,
  input logic [TW-1:0] wd_cnt
);
  p_release_on_timeout_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !sda_oe_o);

  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  p_quiet_when_expired_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_expired |-> !sda_oe_o);

  p_drive_only_scl_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  p_no_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_armed && start_p && wd_cnt != '1) |=> (wd_armed && wd_cnt == $past(wd_cnt) + 1'b1));
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.TW(TIMEOUT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_oe_o   (sda_oe_o),
  .timeout_o  (timeout_o),
  .scl_s      (scl_s),
  .start_p    (start_p),
  .wd_armed   (wd_armed),
  .wd_expired (wd_expired),
  .wd_cnt     (wd_cnt)
);

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
  localparam logic [6:0] ADDR = 7'h36;
  localparam int TW  = 12;
  localparam int LIM = 1 << TW;
  localparam int H   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_oe, timeout;
  logic sda_bus;
  int   cyc = 0;
  int   t_start = 0;
  int   to_cnt = 0;
  int   to_cyc = 0;
  int   n_tests = 0;
  int   n_fail = 0;
  bit   done = 0;

  always #2 clk = ~clk;
  assign sda_bus = host_sda & ~sda_oe;

  i2c_reg_target #(.DEV_ADDR(ADDR), .TIMEOUT_W(TW), .REG_AW(4)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_bus),
    .sda_oe_o  (sda_oe),
    .timeout_o (timeout)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (timeout) begin to_cnt++; to_cyc = cyc; end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wc(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start(input bit mark);
    host_sda = 1'b1; wc(H);
    scl = 1'b1; wc(H);
    host_sda = 1'b0;
    if (mark) t_start = cyc;
    wc(H);
    scl = 1'b0; wc(H);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wc(H);
    scl = 1'b1; wc(H);
    host_sda = 1'b1; wc(H);
  endtask

  task automatic send_bit(input bit b);
    host_sda = b; wc(H);
    scl = 1'b1; wc(H);
    scl = 1'b0; wc(H);
  endtask

  task automatic recv_bit(output bit b);
    host_sda = 1'b1; wc(H);
    scl = 1'b1; wc(H/2);
    b = sda_bus; wc(H/2);
    scl = 1'b0; wc(H);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
    send_bit(nack);
  endtask

  task automatic set_ptr(input logic [15:0] p);
    bit a;
    send_byte({ADDR, 1'b0}, a); check("R2 addr ack", a, 1);
    send_byte(p[15:8], a);      check("R3 ptr hi ack", a, 1);
    send_byte(p[7:0], a);       check("R3 ptr lo ack", a, 1);
  endtask

  task automatic t_reset();
    check("R1 sda_oe after reset", sda_oe, 0);
    check("R1 timeout after reset", timeout, 0);
  endtask

  task automatic t_write_read();
    bit a; logic [7:0] d;
    bus_start(1); set_ptr(16'h0002);
    send_byte(8'hA5, a); check("R3 data ack", a, 1);
    send_byte(8'h3C, a); check("R3 data ack", a, 1);
    bus_stop();
    bus_start(1); set_ptr(16'h0002);
    bus_start(0);
    send_byte({ADDR, 1'b1}, a); check("R2 read addr ack", a, 1);
    recv_byte(0, d); check("R4 first byte", d, 8'hA5);
    recv_byte(0, d); check("R4 incremented byte", d, 8'h3C);
    recv_byte(1, d); check("R1 untouched reg zero", d, 8'h00);
    check("R4 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_wrong_addr();
    bit a;
    bus_start(1);
    send_byte({ADDR ^ 7'h01, 1'b0}, a); check("R2 mismatch no ack", a, 0);
    check("R2 mismatch not driving", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_alias();
    bit a; logic [7:0] d;
    bus_start(1); set_ptr(16'h7FF3);
    bus_start(0);
    send_byte({ADDR, 1'b1}, a); check("R2 read addr ack", a, 1);
    recv_byte(1, d); check("R5 aliased read", d, 8'h3C);
    bus_stop();
    check("R8 no timeout across stopped txns", to_cnt, 0);
  endtask

  task automatic t_stall_timeout();
    int base = to_cnt; int guard = 0;
    bus_start(1);
    for (int i = 7; i >= 0; i--) send_bit(ADDR[i > 0 ? i - 1 : 0] & (i > 0) | ((i == 0) ? 1'b0 : 1'b0));
    host_sda = 1'b1; wc(H);
    scl = 1'b1; wc(H);
    check("R2 ack held low", sda_bus, 0);
    while (to_cnt == base && guard < 3 * LIM) begin wc(1); guard++; end
    check("R6 timeout delay", to_cyc - t_start, LIM + 3);
    check("R9 released with scl high", sda_oe, 0);
    check("R9 false stop level", sda_bus & scl, 1);
    wc(4);
    check("R6 single pulse", timeout, 0);
    scl = 1'b0; wc(H);
    bus_stop();
  endtask

  task automatic t_restart();
    bit a; int base = to_cnt; int guard = 0;
    bus_start(1);
    send_byte({ADDR, 1'b0}, a); check("R2 addr ack", a, 1);
    bus_start(0);
    send_byte({ADDR, 1'b0}, a); check("R7 ack after restart", a, 1);
    while (to_cnt == base && guard < 3 * LIM) begin wc(1); guard++; end
    check("R7 window from first start", to_cyc - t_start, LIM + 3);
    bus_stop();
  endtask

  task automatic t_read_timeout();
    bit a; logic [7:0] d; int base; int post = 0;
    bus_start(1); set_ptr(16'h0002);
    bus_start(0);
    send_byte({ADDR, 1'b1}, a); check("R2 read addr ack", a, 1);
    base = to_cnt;
    for (int i = 0; i < 30; i++) begin
      bit pre = (to_cnt != base);
      recv_byte(0, d);
      if (i == 0) check("R4 read before timeout", d, 8'hA5);
      if (pre) begin
        check("R9 ones after timeout", d, 8'hFF);
        post++;
        if (post == 3) break;
      end
    end
    check("R9 timeout seen during read", post, 3);
    bus_stop();
  endtask

  task automatic t_recover();
    bit a; logic [7:0] d;
    bus_start(1); set_ptr(16'h0003);
    bus_start(0);
    send_byte({ADDR, 1'b1}, a); check("R10 ack after recovery", a, 1);
    recv_byte(1, d); check("R10 read after recovery", d, 8'h3C);
    bus_stop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    wc(5);
    t_reset();
    rst_n = 1'b1;
    wc(5);
    t_reset();
    t_write_read();
    t_wrong_addr();
    t_alias();
    t_stall_timeout();
    t_restart();
    t_read_timeout();
    t_recover();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run hung, actual running expected done");
    finish_run();
  end
endmodule